// File: doc/BRIEF.md
# Cascaded Filter Chain Freeze Sequencer

This controller parks a chain of cascaded filter stages in a frozen or low-power condition and later releases them. Stage 0 is the head of the chain and stage NUM_STAGES-1 is the tail. An entry command walks the chain from head to tail. At each stage the controller raises that stage's freeze request and then waits for the stage to report that it is no longer busy before it moves on. An exit command walks the chain back from tail to head. At each stage the controller drops the request and leaves one idle cycle before it handles the next stage.

Commands arrive as single-cycle pulses. A one-cycle done pulse marks the end of either walk. A command that arrives while a walk is running is dropped, and a sticky error flag records it. If a stage stays busy too long, the controller halts with a sticky timeout flag and keeps the index of the stage it was waiting on. After that, only reset brings it back.

Top module: `chain_freeze_seq`

## Requirements
- R1: While and after reset, all `frz_req_o` bits are 0, `done_o`, `cmd_err_o` and `tmo_o` are 0, and `tmo_stage_o` is 0.
- R2: Entry raises the request of stage 0 first. Each later stage is raised only after the previous stage's busy input has been read low. Call the command's sampling edge edge 0. The request of stage i then rises at edge 1 + sum over j<i of (3 + D_j), where D_j is the number of consecutive cycles stage j reads busy during its wait.
- R3: Once a stage's request is set, it stays set until the exit walk clears it. At most one request bit changes per cycle.
- R4: Exit clears the requests from the tail toward the head without looking at busy. The request of stage s falls at edge 2*(NUM_STAGES-1-s)+1 after the command edge, so one quiet cycle separates successive drops.
- R5: `done_o` is high for exactly one cycle. For entry it follows edge sum of (3 + D_i) over all stages. For exit it follows edge 2*NUM_STAGES.
- R6: An `enter_i` or `exit_i` pulse that arrives while a walk is running, or while the controller is halted, has no effect on requests or timing, and it sets `cmd_err_o`, which then stays 1 until reset. Commands accepted while idle leave `cmd_err_o` at 0.
- R7: Suppose the current stage reads busy on more than `tmo_limit_i` consecutive wait cycles. On the (limit+1)-th busy read, the controller halts: `tmo_o` rises and stays 1, `tmo_stage_o` holds the stage index, and the requests freeze with no `done_o`. A stage that reads busy on exactly `tmo_limit_i` wait cycles does not trip the timeout.
- R8: If `enter_i` and `exit_i` are both high in the same idle cycle, the entry walk runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Single-cycle entry command |
| exit_i | input | 1 | Single-cycle exit command |
| tmo_limit_i | input | TMO_W | Longest busy run tolerated per stage, in cycles |
| busy_i | input | NUM_STAGES | Busy flag from each stage |
| frz_req_o | output | NUM_STAGES | Freeze/low-power request to each stage |
| done_o | output | 1 | One-cycle pulse when a walk completes |
| cmd_err_o | output | 1 | Sticky: command received while not idle |
| tmo_o | output | 1 | Sticky: busy timeout occurred |
| tmo_stage_o | output | IDX_W | Index of the stage that timed out |

## Verification
The entry walk is swept over every combination of busy lengths {0, 1, 3} on four stages. Each combination is followed by an exit walk, and the bench checks the whole request vector and `done_o` on every cycle against raise and drop edges it derives from the sums in R2, R4 and R5. The zero-length cases separate the fixed settle overhead from the busy wait, and unequal lengths show that the controller reads each stage's own busy flag rather than a neighbour's.

Timeout is exercised for each stage at limits 0 and 2, once with a busy length one cycle over the limit and once with a length exactly at the limit. These two cases pin down the off-by-one edge of R7. Stray commands are issued mid-walk and while halted, and both-commands-at-once is issued while idle, to separate the cases that must be ignored from the one that must be accepted.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAISE,
    ST_SETTLE,
    ST_WAIT,
    ST_DROP,
    ST_GAP,
    ST_HALT
  } cfs_state_e;
endpackage

// File: rtl/cfs_timer.sv
module cfs_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             busy_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             hit_o
);
  logic [TMO_W-1:0] cnt_q;

  assign hit_o = run_i && busy_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (busy_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfs_req_bank.sv
module cfs_req_bank #(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_i,
  input  logic                  clr_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [NUM_STAGES-1:0] req_o
);
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic sel;
    assign sel = (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[g] <= 1'b0;
      else if (set_i && sel) req_o[g] <= 1'b1;
      else if (clr_i && sel) req_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cfs_ctrl.sv
module cfs_ctrl
  import cfs_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic             busy_sel_i,
  input  logic             tmo_hit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             set_en_o,
  output logic             clr_en_o,
  output logic             wait_o,
  output logic             done_o,
  output logic             cmd_err_o,
  output logic             tmo_o,
  output logic [IDX_W-1:0] tmo_stage_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_STAGES - 1);

  cfs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign idx_o    = idx_q;
  assign set_en_o = (state_q == ST_RAISE);
  assign clr_en_o = (state_q == ST_DROP);
  assign wait_o   = (state_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      done_o      <= 1'b0;
      cmd_err_o   <= 1'b0;
      tmo_o       <= 1'b0;
      tmo_stage_o <= '0;
    end else begin
      done_o <= 1'b0;
      if ((enter_i || exit_i) && state_q != ST_IDLE) cmd_err_o <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (enter_i) begin
            idx_q   <= '0;
            state_q <= ST_RAISE;
          end else if (exit_i) begin
            idx_q   <= LAST;
            state_q <= ST_DROP;
          end
        end
        ST_RAISE:  state_q <= ST_SETTLE;
        ST_SETTLE: state_q <= ST_WAIT;  // let the stage report busy
        ST_WAIT: begin
          if (tmo_hit_i) begin
            state_q     <= ST_HALT;
            tmo_o       <= 1'b1;
            tmo_stage_o <= idx_q;
          end else if (!busy_sel_i) begin
            if (idx_q == LAST) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_RAISE;
            end
          end
        end
        ST_DROP: state_q <= ST_GAP;
        ST_GAP: begin
          if (idx_q == '0) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_DROP;
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_freeze_seq.sv
module chain_freeze_seq #(
  parameter int NUM_STAGES = 4,
  parameter int TMO_W      = 8,
  parameter int IDX_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enter_i,
  input  logic                  exit_i,
  input  logic [TMO_W-1:0]      tmo_limit_i,
  input  logic [NUM_STAGES-1:0] busy_i,
  output logic [NUM_STAGES-1:0] frz_req_o,
  output logic                  done_o,
  output logic                  cmd_err_o,
  output logic                  tmo_o,
  output logic [IDX_W-1:0]      tmo_stage_o
);
  logic [IDX_W-1:0] idx;
  logic set_en, clr_en, wait_st, busy_sel, tmo_hit;

  assign busy_sel = busy_i[idx];

  cfs_ctrl #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .enter_i, .exit_i,
    .busy_sel_i (busy_sel),
    .tmo_hit_i  (tmo_hit),
    .idx_o      (idx),
    .set_en_o   (set_en),
    .clr_en_o   (clr_en),
    .wait_o     (wait_st),
    .done_o, .cmd_err_o, .tmo_o, .tmo_stage_o
  );

  cfs_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i, .rst_ni,
    .run_i   (wait_st),
    .busy_i  (busy_sel),
    .limit_i (tmo_limit_i),
    .hit_o   (tmo_hit)
  );

  cfs_req_bank #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_reqs (
    .clk_i, .rst_ni,
    .set_i (set_en),
    .clr_i (clr_en),
    .idx_i (idx),
    .req_o (frz_req_o)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_STAGES-1:0] busy_i,
  input logic [NUM_STAGES-1:0] frz_req_o,
  input logic                  done_o,
  input logic                  cmd_err_o,
  input logic                  tmo_o,
  input logic [IDX_W-1:0]      tmo_stage_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);

  assert_tmo_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> tmo_o && $stable(tmo_stage_o) && $stable(frz_req_o) && !done_o);

  assert_one_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> $countones(frz_req_o ^ $past(frz_req_o)) <= 1);

  assert_head_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(frz_req_o[0])) |-> $countones(frz_req_o) == 1);

  assert_tail_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(frz_req_o[NUM_STAGES-1])) |-> $past(&frz_req_o));

  for (genvar g = 1; g < NUM_STAGES; g++) begin : g_ord
    assert_entry_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $rose(frz_req_o[g])) |-> frz_req_o[g-1] && !$past(busy_i[g-1]));
    assert_exit_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $fell(frz_req_o[g-1])) |-> !$past(frz_req_o[g]));
  end
endmodule

bind chain_freeze_seq cfs_checker #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/chain_freeze_seq_test.sv
`timescale 1ns/1ps
module chain_freeze_seq_test;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enter_i = 1'b0, exit_i = 1'b0;
  logic [TW-1:0] tmo_limit_i = 8'd5;
  logic [N-1:0]  busy_i;
  logic [N-1:0]  frz_req_o;
  logic          done_o, cmd_err_o, tmo_o;
  logic [IW-1:0] tmo_stage_o;

  int total = 0, bad = 0, cyc = 0;
  int dly [N];
  int bcnt [N];
  logic [N-1:0] req_q;

  always #2.5 clk_i = ~clk_i;

  chain_freeze_seq #(.NUM_STAGES(N), .TMO_W(TW)) uut (.*);

  // stage responder: busy for dly[i] cycles after its request rises
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      for (int i = 0; i < N; i++) bcnt[i] <= 0;
    end else begin
      req_q <= frz_req_o;
      for (int i = 0; i < N; i++)
        if (frz_req_o[i] && !req_q[i]) bcnt[i] <= dly[i];
        else if (bcnt[i] > 0) bcnt[i] <= bcnt[i] - 1;
    end
  end
  always_comb for (int i = 0; i < N; i++) busy_i[i] = (bcnt[i] != 0);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; enter_i = 1'b0; exit_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // entry walk; inject pulses exit_i mid-walk; both drives exit_i with enter_i
  task automatic run_entry(bit inject, bit both);
    int rise [N];
    int r = 1;
    int tot;
    logic [N-1:0] exp_req;
    for (int i = 0; i < N; i++) begin rise[i] = r; r += 3 + dly[i]; end
    tot = r - 1;
    @(negedge clk_i); enter_i = 1'b1; exit_i = both;
    @(negedge clk_i); enter_i = 1'b0; exit_i = 1'b0;
    for (int k = 1; k <= tot + 2; k++) begin
      @(negedge clk_i);
      for (int i = 0; i < N; i++) exp_req[i] = (k >= rise[i]);
      chk("R2 entry request vector", int'(frz_req_o), int'(exp_req));
      chk("R5 entry done timing", int'(done_o), int'(k == tot));
      exit_i = (inject && k == 2);
    end
    exit_i = 1'b0;
    chk("R3 all stages held after entry", int'(frz_req_o), (1 << N) - 1);
  endtask

  task automatic run_exit();
    logic [N-1:0] exp_req;
    @(negedge clk_i); exit_i = 1'b1;
    @(negedge clk_i); exit_i = 1'b0;
    for (int k = 1; k <= 2 * N + 2; k++) begin
      @(negedge clk_i);
      for (int s = 0; s < N; s++) exp_req[s] = !(k >= 2 * (N - 1 - s) + 1);
      chk("R4 exit request vector", int'(frz_req_o), int'(exp_req));
      chk("R5 exit done timing", int'(done_o), int'(k == 2 * N));
    end
  endtask

  task automatic run_tmo(int s, int lim);
    int rise [N];
    int hit;
    logic [N-1:0] exp_req;
    for (int i = 0; i < N; i++) rise[i] = 1 + 3 * i;
    hit = rise[s] + 2 + lim;
    @(negedge clk_i); enter_i = 1'b1;
    @(negedge clk_i); enter_i = 1'b0;
    for (int k = 1; k <= hit + 3; k++) begin
      @(negedge clk_i);
      for (int i = 0; i < N; i++) exp_req[i] = (i <= s) && (k >= rise[i]);
      chk("R7 timeout flag timing", int'(tmo_o), int'(k >= hit));
      chk("R7 requests frozen at halt", int'(frz_req_o), int'(exp_req));
      chk("R7 no done on timeout", int'(done_o), 0);
    end
    chk("R7 recorded stage", int'(tmo_stage_o), s);
    chk("R6 no error before stray command", int'(cmd_err_o), 0);
    @(negedge clk_i); exit_i = 1'b1;
    @(negedge clk_i); exit_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R6 halted ignores exit", int'(frz_req_o), int'(exp_req));
    chk("R6 error set while halted", int'(cmd_err_o), 1);
    chk("R7 timeout sticky", int'(tmo_o), 1);
  endtask

  initial begin
    int vals [3] = '{0, 1, 3};
    for (int i = 0; i < N; i++) dly[i] = 0;
    do_reset();
    chk("R1 requests after reset", int'(frz_req_o), 0);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 cmd_err after reset", int'(cmd_err_o), 0);
    chk("R1 tmo after reset", int'(tmo_o), 0);
    chk("R1 tmo_stage after reset", int'(tmo_stage_o), 0);

    // R8: both commands at once in idle -> entry
    run_entry(1'b0, 1'b1);
    chk("R8 both commands start entry", int'(frz_req_o), (1 << N) - 1);
    run_exit();

    tmo_limit_i = 8'd5;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++) begin
            bit inj;
            dly[0] = vals[a]; dly[1] = vals[b]; dly[2] = vals[c]; dly[3] = vals[d];
            inj = (a == 2 && b == 2 && c == 2 && d == 2);
            run_entry(inj, 1'b0);
            run_exit();
            chk("R6 error flag state", int'(cmd_err_o), int'(inj));
            chk("R7 no timeout within limit", int'(tmo_o), 0);
          end

    for (int lim = 0; lim <= 2; lim += 2)
      for (int s = 0; s < N; s++) begin
        do_reset();
        tmo_limit_i = TW'(lim);
        for (int i = 0; i < N; i++) dly[i] = 0;
        dly[s] = lim + 1;
        run_tmo(s, lim);
        do_reset();
        dly[s] = lim;
        run_entry(1'b0, 1'b0);
        chk("R7 busy equal to limit does not trip", int'(tmo_o), 0);
        run_exit();
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule